// File: doc/BRIEF.md
# Address Map Decoder with Boot Remap

This block sorts every processor address into one of three regions: on-chip memory in the bottom 4 MB, peripherals in the top 4 MB, and the external bus for everything between. It drives a one-hot region select, a one-hot external bank chip select and a one-hot peripheral select. All of these outputs are combinational and are valid in the same cycle as the address strobe.

After reset the lowest megabyte is served by the boot device on external bank 0. On-chip memory can then be reached only through its alias from 1 MB up to 4 MB. Writing a one to the remap control puts the internal SRAM at address zero, and the remap state stays set until the next reset. External banks are eight 1 MB windows starting at 0x0040_0000, and a bank is reachable only after remap has been performed.

An external access that hits no reachable, enabled bank raises abort. Accesses to internal memory or to the peripheral space never abort, even when no peripheral answers. Each ordinary peripheral owns a 16 KB window counted down from the top slot. The interrupt controller owns only the uppermost 4 KB of that top slot.

Top module: `amap_decoder`

## Requirements
- R1: After a synchronous reset the remap state output is 0. Reset takes precedence over a remap write in the same cycle.
- R2: A remap write with data 1 sets the remap state from the next cycle on. A remap write with data 0 changes nothing, and once the state is set it stays 1 until reset.
- R3: With remap clear, an address below 1 MB selects the external region (region code 3'b010) and bank select bit 0, and does not abort.
- R4: With remap set, any address below 4 MB selects internal memory (region code 3'b001), with no bank select and no abort.
- R5: With remap clear, addresses from 1 MB up to 4 MB select internal memory (3'b001).
- R6: With remap set, an address in window i (0x0040_0000 + i·1 MB, 1 MB long) of an enabled bank asserts only bank select bit i, with region 3'b010 and no abort.
- R7: With remap clear, every address in the bank windows aborts and asserts no bank select.
- R8: An address between 4 MB and the peripheral base that lies outside every enabled bank window asserts abort, with region 3'b010 and no bank select. A bank disabled by the enable mask counts as outside.
- R9: Addresses from 0xFFC0_0000 up select the peripheral region (3'b100) and never abort.
- R10: Peripheral select bit 0 (the interrupt controller) is set for 0xFFFF_F000–0xFFFF_FFFF. Bit i≥1 is set for the 16 KB slot i places below the top slot (bit 1 at 0xFFFF_8000). Other peripheral addresses, including 0xFFFF_C000–0xFFFF_EFFF, assert no peripheral select.
- R11: While the address strobe is low, the region, bank select, peripheral select and abort outputs are all zero, and region is never more than one-hot.
- R12: Region, selects and abort follow the address in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Processor address |
| addr_vld_i | input | 1 | Address strobe |
| remap_wr_i | input | 1 | Write strobe to the remap control |
| remap_wdata_i | input | 1 | Data bit written to the remap control |
| region_o | output | 3 | One-hot region: bit0 internal memory, bit1 external, bit2 peripheral |
| bank_cs_o | output | NUM_BANKS | One-hot external bank select |
| periph_sel_o | output | NUM_PERIPH | One-hot peripheral select |
| remapped_o | output | 1 | Remap state |
| abort_o | output | 1 | Undefined external access |

## Verification
A remap write and an access to address zero can fall in the same cycle. The bench provokes this by holding the strobe on address 0 while it pulses the remap write. That cycle must still decode as a boot-device access on bank 0, and the following cycle must decode as internal memory. A second collision is reset together with a remap write: the state must read 0 afterwards. After that, address 0 must again select bank 0.

// File: rtl/amap_pkg.sv
package amap_pkg;

    // One-hot region select; bit 0 internal memory, bit 1 external, bit 2 peripheral
    typedef struct packed {
        logic periph;
        logic ext;
        logic intmem;
    } region_sel_t;

    // Coarse classification by the bits above the low region size
    typedef enum logic [1:0] {
        AREA_NONE = 2'd0,
        AREA_LOW  = 2'd1,
        AREA_EXT  = 2'd2,
        AREA_TOP  = 2'd3
    } area_e;

    // Number of equal slots of size 2**slot_log2 inside a window of 2**win_log2
    function automatic int unsigned slot_count(input int unsigned win_log2,
                                               input int unsigned slot_log2);
        return 32'd1 << (win_log2 - slot_log2);
    endfunction

endpackage

// File: rtl/amap_remap_flag.sv
module amap_remap_flag (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic wdata_i,
    output logic set_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_o <= 1'b0;
        end else if (wr_i && wdata_i) begin
            set_o <= 1'b1;
        end
    end

    // R2: a one written takes effect on the next cycle
    p_set_on_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i) |=> set_o);

    // R2: once set, the flag holds until reset
    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        set_o |=> set_o);

    // R2: writing zero leaves a clear flag clear
    p_zero_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !wdata_i && !set_o) |=> !set_o);

endmodule

// File: rtl/amap_ext_banks.sv
module amap_ext_banks #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BANK_LOG2 = 20,
    parameter int unsigned NUM_BANKS = 8,
    parameter logic [ADDR_W-1:0]    EXT_BASE = 32'h0040_0000,
    parameter logic [NUM_BANKS-1:0] BANK_EN  = '1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-BANK_LOG2-1:0] bank_idx_i,
    input  logic                        in_ext_i,
    input  logic                        boot_hit_i,
    input  logic                        remapped_i,
    output logic [NUM_BANKS-1:0]        cs_o,
    output logic                        miss_o
);

    localparam int unsigned IDX_W = ADDR_W - BANK_LOG2;
    localparam logic [IDX_W-1:0] BASE_IDX = IDX_W'(EXT_BASE >> BANK_LOG2);

    logic [NUM_BANKS-1:0] win_hit;

    // One comparator per bank window; banks are gated until remap is done
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign win_hit[b] = in_ext_i && remapped_i && BANK_EN[b] &&
                            (bank_idx_i == BASE_IDX + IDX_W'(b));
    end

    always_comb begin
        cs_o    = win_hit;
        cs_o[0] = win_hit[0] | boot_hit_i;
    end

    assign miss_o = in_ext_i && (win_hit == '0);

    // R6: at most one bank selected
    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_o));

    // R7: upper banks unreachable before remap
    p_upper_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !remapped_i |-> (cs_o[NUM_BANKS-1:1] == '0));

    // R8: a miss never comes with a bank select
    p_miss_no_cs_r8: assert property (@(posedge clk) disable iff (rst)
        miss_o |-> (cs_o == '0));

endmodule

// File: rtl/amap_periph_sel.sv
module amap_periph_sel #(
    parameter int unsigned LOW_LOG2   = 22,
    parameter int unsigned SLOT_LOG2  = 14,
    parameter int unsigned IRQ_LOG2   = 12,
    parameter int unsigned NUM_PERIPH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [LOW_LOG2-1:IRQ_LOG2]   offs_i,
    input  logic                         in_top_i,
    output logic [NUM_PERIPH-1:0]        sel_o
);

    import amap_pkg::*;

    localparam int unsigned SLOT_W = LOW_LOG2 - SLOT_LOG2;
    localparam int unsigned NSLOT  = slot_count(LOW_LOG2, SLOT_LOG2);

    logic [SLOT_W-1:0]             slot;
    logic [SLOT_LOG2-1:IRQ_LOG2]   sub;

    assign slot = offs_i[LOW_LOG2-1:SLOT_LOG2];
    assign sub  = offs_i[SLOT_LOG2-1:IRQ_LOG2];

    // The interrupt controller owns only the uppermost sub-window of the top slot
    assign sel_o[0] = in_top_i && (slot == SLOT_W'(NSLOT - 1)) && (&sub);

    // Ordinary peripherals count down from the slot below the top one
    for (genvar p = 1; p < NUM_PERIPH; p++) begin : g_slot
        assign sel_o[p] = in_top_i && (slot == SLOT_W'(NSLOT - 1 - p));
    end

    // R10: at most one peripheral selected
    p_psel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    // R10: a select only inside the peripheral region
    p_psel_in_top_r10: assert property (@(posedge clk) disable iff (rst)
        (|sel_o) |-> in_top_i);

endmodule

// File: rtl/amap_decoder.sv
module amap_decoder #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LOW_LOG2   = 22,
    parameter int unsigned BOOT_LOG2  = 20,
    parameter int unsigned BANK_LOG2  = 20,
    parameter int unsigned NUM_BANKS  = 8,
    parameter logic [ADDR_W-1:0]    EXT_BASE = 32'h0040_0000,
    parameter logic [NUM_BANKS-1:0] BANK_EN  = '1,
    parameter int unsigned SLOT_LOG2  = 14,
    parameter int unsigned IRQ_LOG2   = 12,
    parameter int unsigned NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  addr_vld_i,
    input  logic                  remap_wr_i,
    input  logic                  remap_wdata_i,
    output logic [2:0]            region_o,
    output logic [NUM_BANKS-1:0]  bank_cs_o,
    output logic [NUM_PERIPH-1:0] periph_sel_o,
    output logic                  remapped_o,
    output logic                  abort_o
);

    import amap_pkg::*;

    localparam int unsigned HI_W = ADDR_W - LOW_LOG2;

    logic [HI_W-1:0] hi;
    area_e           area;
    logic            remapped;
    logic            boot_hit;
    logic            ext_miss;
    region_sel_t     rsel;
    logic            unused_low_bits;

    assign hi = addr_i[ADDR_W-1:LOW_LOG2];
    assign unused_low_bits = ^addr_i[IRQ_LOG2-1:0];

    always_comb begin
        if (!addr_vld_i)       area = AREA_NONE;
        else if (hi == '0)     area = AREA_LOW;
        else if (&hi)          area = AREA_TOP;
        else                   area = AREA_EXT;
    end

    amap_remap_flag i_remap (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (remap_wr_i),
        .wdata_i (remap_wdata_i),
        .set_o   (remapped)
    );

    // Before remap the lowest window belongs to the boot device on bank 0
    assign boot_hit = (area == AREA_LOW) && !remapped &&
                      (addr_i[LOW_LOG2-1:BOOT_LOG2] == '0);

    always_comb begin
        rsel        = '0;
        rsel.intmem = (area == AREA_LOW) && !boot_hit;
        rsel.ext    = (area == AREA_EXT) || boot_hit;
        rsel.periph = (area == AREA_TOP);
    end

    amap_ext_banks #(
        .ADDR_W    (ADDR_W),
        .BANK_LOG2 (BANK_LOG2),
        .NUM_BANKS (NUM_BANKS),
        .EXT_BASE  (EXT_BASE),
        .BANK_EN   (BANK_EN)
    ) i_banks (
        .clk        (clk),
        .rst        (rst),
        .bank_idx_i (addr_i[ADDR_W-1:BANK_LOG2]),
        .in_ext_i   (area == AREA_EXT),
        .boot_hit_i (boot_hit),
        .remapped_i (remapped),
        .cs_o       (bank_cs_o),
        .miss_o     (ext_miss)
    );

    amap_periph_sel #(
        .LOW_LOG2   (LOW_LOG2),
        .SLOT_LOG2  (SLOT_LOG2),
        .IRQ_LOG2   (IRQ_LOG2),
        .NUM_PERIPH (NUM_PERIPH)
    ) i_periph (
        .clk      (clk),
        .rst      (rst),
        .offs_i   (addr_i[LOW_LOG2-1:IRQ_LOG2]),
        .in_top_i (area == AREA_TOP),
        .sel_o    (periph_sel_o)
    );

    assign region_o   = rsel;
    assign remapped_o = remapped;
    assign abort_o    = ext_miss;

    // R11: region is never more than one-hot
    p_region_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region_o));

    // R11: idle strobe leaves every select quiet
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !addr_vld_i |-> (region_o == '0 && bank_cs_o == '0 &&
                         periph_sel_o == '0 && !abort_o));

    // R9: internal memory and peripherals never abort
    p_no_internal_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (region_o[0] || region_o[2]) |-> !abort_o);

    // R8: abort only in the external region
    p_abort_is_ext_r8: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> region_o[1]);

    // R3: boot window goes to bank 0 before remap
    p_boot_bank0_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_vld_i && !remapped_o && addr_i[ADDR_W-1:BOOT_LOG2] == '0)
            |-> (bank_cs_o[0] && region_o[1]));

endmodule

// File: tb/test_amap_decoder.sv
module test_amap_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        vld = 1'b0;
    logic        wr = 1'b0;
    logic        wd = 1'b0;
    logic [2:0]  region;
    logic [7:0]  cs;
    logic [7:0]  psel;
    logic        remapped;
    logic        abort_s;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // Bank 7 disabled so that the enable mask is exercised
    amap_decoder #(.BANK_EN(8'h7F)) i_amap_decoder (
        .clk           (clk),
        .rst           (rst),
        .addr_i        (addr),
        .addr_vld_i    (vld),
        .remap_wr_i    (wr),
        .remap_wdata_i (wd),
        .region_o      (region),
        .bank_cs_o     (cs),
        .periph_sel_o  (psel),
        .remapped_o    (remapped),
        .abort_o       (abort_s)
    );

    typedef struct packed {
        logic        pre;
        logic [31:0] a;
        logic [2:0]  rg;
        logic [7:0]  cs;
        logic [7:0]  ps;
        logic        ab;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h0000_0000, 3'b010, 8'h01, 8'h00, 1'b0, 4'd3},  // R3
        '{1'b1, 32'h000F_FFFC, 3'b010, 8'h01, 8'h00, 1'b0, 4'd3},  // R3
        '{1'b1, 32'h0010_0000, 3'b001, 8'h00, 8'h00, 1'b0, 4'd5},  // R5
        '{1'b1, 32'h003F_FFFC, 3'b001, 8'h00, 8'h00, 1'b0, 4'd5},  // R5
        '{1'b1, 32'h0040_0000, 3'b010, 8'h00, 8'h00, 1'b1, 4'd7},  // R7
        '{1'b1, 32'h0050_0000, 3'b010, 8'h00, 8'h00, 1'b1, 4'd7},  // R7
        '{1'b1, 32'hFFFF_F000, 3'b100, 8'h00, 8'h01, 1'b0, 4'd9},  // R9
        '{1'b0, 32'h0000_0000, 3'b001, 8'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b0, 32'h000F_FFFC, 3'b001, 8'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{1'b0, 32'h0040_0000, 3'b010, 8'h01, 8'h00, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h004F_FFFF, 3'b010, 8'h01, 8'h00, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h0050_0000, 3'b010, 8'h02, 8'h00, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h0080_0010, 3'b010, 8'h10, 8'h00, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h00AF_FFFC, 3'b010, 8'h40, 8'h00, 1'b0, 4'd6},  // R6
        '{1'b0, 32'h00B0_0000, 3'b010, 8'h00, 8'h00, 1'b1, 4'd8},  // R8 disabled bank
        '{1'b0, 32'h00C0_0000, 3'b010, 8'h00, 8'h00, 1'b1, 4'd8},  // R8
        '{1'b0, 32'h8000_0000, 3'b010, 8'h00, 8'h00, 1'b1, 4'd8},  // R8
        '{1'b0, 32'hFFBF_FFFC, 3'b010, 8'h00, 8'h00, 1'b1, 4'd8},  // R8
        '{1'b0, 32'hFFC0_0000, 3'b100, 8'h00, 8'h00, 1'b0, 4'd9},  // R9
        '{1'b0, 32'hFFFF_C000, 3'b100, 8'h00, 8'h00, 1'b0, 4'd10}, // R10
        '{1'b0, 32'hFFFF_EFFC, 3'b100, 8'h00, 8'h00, 1'b0, 4'd10}, // R10
        '{1'b0, 32'hFFFF_F000, 3'b100, 8'h00, 8'h01, 1'b0, 4'd10}, // R10
        '{1'b0, 32'hFFFF_FFFC, 3'b100, 8'h00, 8'h01, 1'b0, 4'd10}, // R10
        '{1'b0, 32'hFFFF_8000, 3'b100, 8'h00, 8'h02, 1'b0, 4'd10}, // R10
        '{1'b0, 32'hFFFE_0000, 3'b100, 8'h00, 8'h80, 1'b0, 4'd10}, // R10
        '{1'b0, 32'hFFFD_FFFC, 3'b100, 8'h00, 8'h00, 1'b0, 4'd10}  // R10
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [2:0] rg,
                           input logic [7:0] ec, input logic [7:0] ep, input logic ea);
        chk(tag, "region", 32'(region), 32'(rg));
        chk(tag, "bank_cs", 32'(cs), 32'(ec));
        chk(tag, "periph_sel", 32'(psel), 32'(ep));
        chk(tag, "abort", 32'(abort_s), 32'(ea));
    endtask

    // Drive at the falling edge, sample 1 ns later with no rising edge in between (R12)
    task automatic drive(input logic [31:0] a, input logic v);
        @(negedge clk);
        addr = a;
        vld  = v;
        #1;
    endtask

    task automatic remap_write(input logic d);
        @(negedge clk);
        wr = 1'b1;
        wd = d;
        @(negedge clk);
        wr = 1'b0;
        wd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit done_remap;
        done_remap = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state, R11 idle outputs
        chk("R1", "remapped", 32'(remapped), 32'd0);
        chk_all("R11", 3'b000, 8'h00, 8'h00, 1'b0);

        // R2 writing zero has no effect
        remap_write(1'b0);
        chk("R2", "remapped after zero write", 32'(remapped), 32'd0);

        // R11 strobe low with an address that would abort
        drive(32'h8000_0000, 1'b0);
        chk_all("R11", 3'b000, 8'h00, 8'h00, 1'b0);

        for (int k = 0; k < NV; k++) begin
            string tag;
            if (!VECS[k].pre && !done_remap) begin
                vld = 1'b0;
                remap_write(1'b1);
                chk("R2", "remapped after one write", 32'(remapped), 32'd1);
                done_remap = 1'b1;
            end
            tag = $sformatf("R%0d", VECS[k].req);
            drive(VECS[k].a, 1'b1);
            chk_all(tag, VECS[k].rg, VECS[k].cs, VECS[k].ps, VECS[k].ab);
        end

        // R2 sticky against a later zero write
        remap_write(1'b0);
        chk("R2", "remapped sticky", 32'(remapped), 32'd1);

        // R1 reset clears remap; R3 boot map returns
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "remapped after reset", 32'(remapped), 32'd0);
        drive(32'h0000_0100, 1'b1);
        chk_all("R3", 3'b010, 8'h01, 8'h00, 1'b0);

        // Same cycle: remap write while accessing address 0 (R2, R3, R4)
        @(negedge clk);
        addr = 32'h0000_0000;
        vld  = 1'b1;
        wr   = 1'b1;
        wd   = 1'b1;
        #1;
        chk_all("R3", 3'b010, 8'h01, 8'h00, 1'b0);
        @(negedge clk);
        wr = 1'b0;
        wd = 1'b0;
        #1;
        chk("R2", "remapped after collision", 32'(remapped), 32'd1);
        chk_all("R4", 3'b001, 8'h00, 8'h00, 1'b0);

        // Same cycle: reset together with remap write (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wr  = 1'b1;
        wd  = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wr  = 1'b0;
        wd  = 1'b0;
        #1;
        chk("R1", "reset beats remap write", 32'(remapped), 32'd0);
        chk_all("R3", 3'b010, 8'h01, 8'h00, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule